// File: doc/BRIEF.md
# Ordered Store Queue with Load Forwarding

This block sits between one processor pipeline and a single-ported memory. Stores from the core are queued in program order and leave the queue one per cycle, oldest first, over a valid/ready memory request. The memory sees writes in the exact order the core issued them. Loads search the queue first. When a load address matches one or more queued stores, the load returns the data of the youngest match without waiting for that store to reach memory. When nothing matches, the load reads memory at once and may finish while older, unrelated stores are still queued. That store-then-load bypass is the only reordering the block allows.

Two fence flavours hold the core back until the queue is empty. A full fence stops both loads and stores. A store fence stops only stores. A load that misses takes the memory port ahead of the drain. Only one load is outstanding at a time. Queue depth and address and data widths are parameters.

Top module: `tso_store_buffer`

## Requirements
- R1: Every accepted store reaches memory as a write (`mem_valid`=1, `mem_we`=1, accepted when `mem_ready`=1). Writes carry the issued address and data and appear in issue order. At most one write completes per cycle.
- R2: A load accepted while queued stores match its full word address gets `rsp_valid` in the next cycle. Its `rsp_data` is the data of the most recently issued matching store.
- R3: A load with no queued match issues a read (`mem_we`=0) in its acceptance cycle, taking the port ahead of any pending drain, so older stores can still be queued when it completes. `rsp_valid` rises in the cycle after `mem_rvalid`, and `rsp_data` carries `mem_rdata`.
- R4: If the matching entry leaves for memory in the same cycle that the load is accepted, the load still returns that entry's data.
- R5: With all DEPTH entries occupied, `st_ready` is 0. It returns to 1 once an entry drains.
- R6: A full fence (`fence_valid`=1 with `fence_full`=1) drops `st_ready` and `ld_ready` in its own cycle. If stores are queued, `core_stall` is 1 from the next cycle and both stay low until the queue is empty.
- R7: A store fence (`fence_valid`=1 with `fence_full`=0) drops `st_ready` until the queue is empty, but loads are still accepted and answered.
- R8: After reset the queue is empty, `st_ready`=1, `ld_ready`=1, `core_stall`=0, `mem_valid`=0 and `rsp_valid`=0.
- R9: A store accepted in the same cycle as a load counts as younger than that load and is not forwarded to it.
- R10: From acceptance of a missing load until its response, `ld_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request accepted when high |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Load request valid |
| ld_ready | output | 1 | Load request accepted when high |
| ld_addr | input | AW | Load word address |
| rsp_valid | output | 1 | Load response valid |
| rsp_data | output | DW | Load response data |
| fence_valid | input | 1 | Fence request (single-cycle pulse) |
| fence_full | input | 1 | 1 = full fence, 0 = store fence |
| core_stall | output | 1 | A fence waits for the queue to empty |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = write (drain), 0 = read (load miss) |
| mem_addr | output | AW | Memory request address |
| mem_wdata | output | DW | Memory write data |
| mem_rvalid | input | 1 | Read data valid, one response per read |
| mem_rdata | input | DW | Read data |

## Verification
The hardest cases to reach all depend on the memory port being held back. These are a forwarding hit against the head entry in the very cycle it drains, a missing load that overtakes queued stores, and a store and a load to the same word accepted together. The bench holds `mem_ready` low while it fills the queue to a chosen state. It then raises `mem_ready` on the same edge as the load it wants to race. Every response is compared with a program-order reference image updated at store acceptance, and every memory write is compared with an issue-order log.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

   typedef enum logic [1:0] {
      LD_IDLE  = 2'd0,
      LD_ISSUE = 2'd1,
      LD_WAIT  = 2'd2
   } ld_state_e;

   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/sbuf_ring.sv
module sbuf_ring #(
   parameter int DEPTH          = 8,
   parameter int AW             = 32,
   parameter int DW             = 32,
   parameter bit CLEAR_ON_RESET = 1'b0,
   localparam int PW            = $clog2(DEPTH),
   localparam int CW            = $clog2(DEPTH + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          push,
   input  logic [AW-1:0]                 push_addr,
   input  logic [DW-1:0]                 push_data,
   input  logic                          pop,
   output logic [DEPTH-1:0][AW-1:0]      ord_addr,
   output logic [DEPTH-1:0][DW-1:0]      ord_data,
   output logic [DEPTH-1:0]              ord_vld,
   output logic [AW-1:0]                 head_addr,
   output logic [DW-1:0]                 head_data,
   output logic [CW-1:0]                 count,
   output logic                          full,
   output logic                          empty
);

   logic [PW-1:0]               head_q, tail_q;
   logic [CW-1:0]               cnt_q;
   logic [DEPTH-1:0][AW-1:0]    ent_a;
   logic [DEPTH-1:0][DW-1:0]    ent_d;

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic          we;
      logic [AW-1:0] a_q;
      logic [DW-1:0] d_q;
      assign we = push && (tail_q == PW'(e));
      if (CLEAR_ON_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               a_q <= '0;
               d_q <= '0;
            end else if (we) begin
               a_q <= push_addr;
               d_q <= push_data;
            end
         end
      end else begin : g_nrst
         always_ff @(posedge clk) begin
            if (we) begin
               a_q <= push_addr;
               d_q <= push_data;
            end
         end
      end
      assign ent_a[e] = a_q;
      assign ent_d[e] = d_q;
   end

   // age-ordered view: slot 0 is the oldest entry
   for (genvar a = 0; a < DEPTH; a++) begin : g_ord
      logic [PW-1:0] idx;
      assign idx         = head_q + PW'(a);
      assign ord_addr[a] = ent_a[idx];
      assign ord_data[a] = ent_d[idx];
      assign ord_vld[a]  = CW'(a) < cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) tail_q <= tail_q + PW'(1);
         if (pop)  head_q <= head_q + PW'(1);
         cnt_q <= cnt_q + CW'(push) - CW'(pop);
      end
   end

   assign head_addr = ent_a[head_q];
   assign head_data = ent_d[head_q];
   assign count     = cnt_q;
   assign full      = (cnt_q == CW'(DEPTH));
   assign empty     = (cnt_q == '0);

   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   p_no_underflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/sbuf_fwd.sv
module sbuf_fwd #(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   parameter int DW    = 32
) (
   input  logic [DEPTH-1:0][AW-1:0] ord_addr,
   input  logic [DEPTH-1:0][DW-1:0] ord_data,
   input  logic [DEPTH-1:0]         ord_vld,
   input  logic [AW-1:0]            look_addr,
   output logic                     hit,
   output logic [DW-1:0]            data
);

   // priority chain from oldest to youngest; the last match wins
   logic [DEPTH:0]         hit_c;
   logic [DEPTH:0][DW-1:0] data_c;

   assign hit_c[0]  = 1'b0;
   assign data_c[0] = '0;

   for (genvar a = 0; a < DEPTH; a++) begin : g_chain
      logic m;
      assign m           = ord_vld[a] && (ord_addr[a] == look_addr);
      assign hit_c[a+1]  = hit_c[a] | m;
      assign data_c[a+1] = m ? ord_data[a] : data_c[a];
   end

   assign hit  = hit_c[DEPTH];
   assign data = data_c[DEPTH];

endmodule

// File: rtl/sbuf_fence.sv
module sbuf_fence (
   input  logic clk,
   input  logic rst_n,
   input  logic fence_valid,
   input  logic fence_full,
   input  logic buf_empty,
   output logic blk_st,
   output logic blk_ld,
   output logic stall
);

   logic pend_any_q, pend_full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_any_q  <= 1'b0;
         pend_full_q <= 1'b0;
      end else if (fence_valid && !buf_empty) begin
         pend_any_q  <= 1'b1;
         pend_full_q <= pend_full_q | fence_full;
      end else if (buf_empty) begin
         pend_any_q  <= 1'b0;
         pend_full_q <= 1'b0;
      end
   end

   assign blk_st = pend_any_q | fence_valid;
   assign blk_ld = pend_full_q | (fence_valid & fence_full);
   assign stall  = pend_any_q;

   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && buf_empty && !fence_valid) |=> !stall);

endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer #(
   parameter int DEPTH          = 8,
   parameter int AW             = 32,
   parameter int DW             = 32,
   parameter bit CLEAR_ON_RESET = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          st_valid,
   output logic          st_ready,
   input  logic [AW-1:0] st_addr,
   input  logic [DW-1:0] st_data,
   input  logic          ld_valid,
   output logic          ld_ready,
   input  logic [AW-1:0] ld_addr,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data,
   input  logic          fence_valid,
   input  logic          fence_full,
   output logic          core_stall,
   output logic          mem_valid,
   input  logic          mem_ready,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_rvalid,
   input  logic [DW-1:0] mem_rdata
);
   import sbuf_pkg::*;

   localparam int CW = $clog2(DEPTH + 1);

   if (!is_pow2(DEPTH)) begin : g_bad_depth
      $error("DEPTH must be a power of two and at least 2");
   end
   if (AW < 2 || DW < 1) begin : g_bad_width
      $error("AW must be at least 2 and DW at least 1");
   end

   logic [DEPTH-1:0][AW-1:0] ord_addr;
   logic [DEPTH-1:0][DW-1:0] ord_data;
   logic [DEPTH-1:0]         ord_vld;
   logic [AW-1:0]            head_addr;
   logic [DW-1:0]            head_data;
   logic [CW-1:0]            count;
   logic                     full, empty;
   logic                     blk_st, blk_ld;
   logic                     fwd_hit;
   logic [DW-1:0]            fwd_data;

   ld_state_e                lst_q, lst_d;
   logic [AW-1:0]            lad_q;
   logic                     st_fire, ld_fire, rd_req, pop;
   logic [AW-1:0]            rd_addr;

   assign st_ready = !full && !blk_st;
   assign ld_ready = (lst_q == LD_IDLE) && !blk_ld;
   assign st_fire  = st_valid && st_ready;
   assign ld_fire  = ld_valid && ld_ready;

   // a missing load owns the port ahead of the drain
   assign rd_req  = (ld_fire && !fwd_hit) || (lst_q == LD_ISSUE);
   assign rd_addr = (lst_q == LD_ISSUE) ? lad_q : ld_addr;
   assign pop     = !rd_req && !empty && mem_ready;

   assign mem_valid = rd_req || !empty;
   assign mem_we    = !rd_req;
   assign mem_addr  = rd_req ? rd_addr : head_addr;
   assign mem_wdata = head_data;

   sbuf_ring #(
      .DEPTH(DEPTH), .AW(AW), .DW(DW), .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (st_fire),
      .push_addr (st_addr),
      .push_data (st_data),
      .pop       (pop),
      .ord_addr  (ord_addr),
      .ord_data  (ord_data),
      .ord_vld   (ord_vld),
      .head_addr (head_addr),
      .head_data (head_data),
      .count     (count),
      .full      (full),
      .empty     (empty)
   );

   sbuf_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
      .ord_addr  (ord_addr),
      .ord_data  (ord_data),
      .ord_vld   (ord_vld),
      .look_addr (ld_addr),
      .hit       (fwd_hit),
      .data      (fwd_data)
   );

   sbuf_fence u_fence (
      .clk         (clk),
      .rst_n       (rst_n),
      .fence_valid (fence_valid),
      .fence_full  (fence_full),
      .buf_empty   (empty),
      .blk_st      (blk_st),
      .blk_ld      (blk_ld),
      .stall       (core_stall)
   );

   always_comb begin
      lst_d = lst_q;
      unique case (lst_q)
         LD_IDLE:  if (ld_fire && !fwd_hit) lst_d = mem_ready ? LD_WAIT : LD_ISSUE;
         LD_ISSUE: if (mem_ready) lst_d = LD_WAIT;
         LD_WAIT:  if (mem_rvalid) lst_d = LD_IDLE;
         default:  lst_d = LD_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lst_q     <= LD_IDLE;
         lad_q     <= '0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         lst_q     <= lst_d;
         if (ld_fire) lad_q <= ld_addr;
         rsp_valid <= (ld_fire && fwd_hit) || (lst_q == LD_WAIT && mem_rvalid);
         if (ld_fire && fwd_hit)
            rsp_data <= fwd_data;
         else if (lst_q == LD_WAIT && mem_rvalid)
            rsp_data <= mem_rdata;
      end
   end

   p_full_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CW'(DEPTH)) |-> !st_ready);
   p_fence_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (core_stall && !empty) |-> !st_ready);
   p_hit_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_fire && fwd_hit) |=> rsp_valid);
   p_drain_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_we && mem_ready && !st_fire) |=> (count == $past(count) - CW'(1)));
   p_miss_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_fire && !fwd_hit) |=> !ld_ready);

endmodule

// File: tb/tso_store_buffer_bench.sv
module tso_store_buffer_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        st_valid, st_ready, ld_valid, ld_ready, rsp_valid;
   logic [31:0] st_addr, st_data, ld_addr, rsp_data;
   logic        fence_valid, fence_full, core_stall;
   logic        mem_valid, mem_ready, mem_we, mem_rvalid;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;

   int checks = 0;
   int errs   = 0;
   bit done   = 1'b0;

   logic [31:0] mem_arr [0:63];
   logic [31:0] ref_arr [0:63];
   logic [31:0] qa [0:255];
   logic [31:0] qd [0:255];
   int          qw = 0;
   int          qr = 0;

   always #10 clk = ~clk;

   tso_store_buffer u_tso_store_buffer (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
      .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .fence_valid(fence_valid), .fence_full(fence_full), .core_stall(core_stall),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // memory model with a one-cycle read latency; every write is
   // compared with the issue-order log (R1)
   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (rst_n && mem_valid && mem_ready) begin
         if (mem_we) begin
            if (qr == qw) begin
               checks++; errs++;
               $display("FAIL R1 write with no store pending act=%h exp=none", mem_addr);
            end else begin
               chk("R1 drain address", mem_addr, qa[qr[7:0]]);
               chk("R1 drain data", mem_wdata, qd[qr[7:0]]);
               qr++;
            end
            mem_arr[mem_addr[7:2]] = mem_wdata;
         end else begin
            mem_rdata  <= mem_arr[mem_addr[7:2]];
            mem_rvalid <= 1'b1;
         end
      end
   end

   task automatic st(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      st_valid = 1'b1; st_addr = a; st_data = d;
      #1;
      while (!st_ready) begin @(negedge clk); #1; end
      ref_arr[a[7:2]] = d;
      qa[qw[7:0]] = a; qd[qw[7:0]] = d; qw++;
      @(posedge clk); #1 st_valid = 1'b0;
   endtask

   task automatic wait_rsp(input string tag, input logic [31:0] exp);
      int n = 0;
      @(negedge clk);
      while (!rsp_valid && n < 40) begin @(negedge clk); n++; end
      chk(tag, rsp_data, exp);
   endtask

   task automatic ld(input logic [31:0] a, input string tag);
      logic [31:0] exp;
      @(negedge clk);
      ld_valid = 1'b1; ld_addr = a;
      #1;
      while (!ld_ready) begin @(negedge clk); #1; end
      exp = ref_arr[a[7:2]];
      @(posedge clk); #1 ld_valid = 1'b0;
      wait_rsp(tag, exp);
   endtask

   task automatic drain_wait();
      int n = 0;
      while (qr != qw && n < 100) begin @(negedge clk); n++; end
      chk("R1 queue fully drained", 32'(qw - qr), 32'd0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R8 st_ready", {31'b0, st_ready}, 32'd1);
      chk("R8 ld_ready", {31'b0, ld_ready}, 32'd1);
      chk("R8 core_stall", {31'b0, core_stall}, 32'd0);
      chk("R8 mem_valid", {31'b0, mem_valid}, 32'd0);
      chk("R8 rsp_valid", {31'b0, rsp_valid}, 32'd0);
   endtask

   task automatic t_youngest();
      mem_ready = 1'b0;
      st(32'h10, 32'h1111_0001);
      st(32'h14, 32'h2222_0001);
      st(32'h10, 32'h1111_0002);
      ld(32'h10, "R2 youngest match");
      ld(32'h14, "R2 single match");
      chk("R2 stores still queued", 32'(qw - qr), 32'd3);
   endtask

   task automatic t_bypass();
      logic [31:0] exp;
      @(negedge clk);
      ld_valid = 1'b1; ld_addr = 32'h20; mem_ready = 1'b1;
      exp = ref_arr[8];
      #1;
      chk("R3 miss accepted", {31'b0, ld_ready}, 32'd1);
      @(posedge clk); #1 ld_valid = 1'b0;
      @(negedge clk);
      chk("R10 ld_ready low while miss pending", {31'b0, ld_ready}, 32'd0);
      chk("R3 read overtook queued stores", 32'(qw - qr), 32'd3);
      if (!rsp_valid) @(negedge clk);
      chk("R3 miss data", rsp_data, exp);
      drain_wait();
   endtask

   task automatic t_drain_race();
      logic [31:0] exp;
      mem_ready = 1'b0;
      st(32'h30, 32'hC0C0_0001);
      st(32'h34, 32'hD0D0_0001);
      @(negedge clk);
      ld_valid = 1'b1; ld_addr = 32'h30; mem_ready = 1'b1;
      exp = ref_arr[12];
      #1;
      @(posedge clk); #1 ld_valid = 1'b0;
      chk("R4 head drained at load edge", 32'(qw - qr), 32'd1);
      wait_rsp("R4 hit on draining entry", exp);
      drain_wait();
   endtask

   task automatic t_full();
      mem_ready = 1'b0;
      for (int i = 0; i < 8; i++) st(32'h40 + 32'(4 * i), 32'hF000_0000 + 32'(i));
      @(negedge clk); #1;
      chk("R5 st_ready low when full", {31'b0, st_ready}, 32'd0);
      mem_ready = 1'b1;
      @(negedge clk); #1;
      chk("R5 st_ready back after a drain", {31'b0, st_ready}, 32'd1);
      drain_wait();
   endtask

   task automatic t_same_cycle();
      logic [31:0] exp;
      mem_ready = 1'b0;
      @(negedge clk);
      st_valid = 1'b1; st_addr = 32'h50; st_data = 32'hEEEE_0001;
      ld_valid = 1'b1; ld_addr = 32'h50;
      #1;
      chk("R9 both accepted", {30'b0, st_ready, ld_ready}, 32'd3);
      exp = ref_arr[20];
      ref_arr[20] = 32'hEEEE_0001;
      qa[qw[7:0]] = 32'h50; qd[qw[7:0]] = 32'hEEEE_0001; qw++;
      @(posedge clk); #1 begin st_valid = 1'b0; ld_valid = 1'b0; end
      @(negedge clk); mem_ready = 1'b1;
      wait_rsp("R9 same-cycle store not forwarded", exp);
      ld(32'h50, "R2 later load sees the store");
      drain_wait();
   endtask

   task automatic t_full_fence();
      int n = 0;
      mem_ready = 1'b0;
      st(32'h58, 32'hAAAA_0001);
      st(32'h5C, 32'hAAAA_0002);
      @(negedge clk);
      fence_valid = 1'b1; fence_full = 1'b1;
      #1;
      chk("R6 fence cycle blocks stores", {31'b0, st_ready}, 32'd0);
      chk("R6 fence cycle blocks loads", {31'b0, ld_ready}, 32'd0);
      @(posedge clk); #1 fence_valid = 1'b0;
      @(negedge clk);
      chk("R6 core_stall raised", {31'b0, core_stall}, 32'd1);
      chk("R6 loads held", {31'b0, ld_ready}, 32'd0);
      mem_ready = 1'b1;
      while (core_stall && n < 50) begin @(negedge clk); n++; end
      chk("R6 queue empty at release", 32'(qw - qr), 32'd0);
      chk("R6 loads resume", {31'b0, ld_ready}, 32'd1);
   endtask

   task automatic t_store_fence();
      int n = 0;
      mem_ready = 1'b0;
      st(32'h60, 32'hBBBB_0001);
      @(negedge clk);
      fence_valid = 1'b1; fence_full = 1'b0;
      @(posedge clk); #1 fence_valid = 1'b0;
      @(negedge clk);
      chk("R7 core_stall raised", {31'b0, core_stall}, 32'd1);
      chk("R7 stores held", {31'b0, st_ready}, 32'd0);
      chk("R7 loads open", {31'b0, ld_ready}, 32'd1);
      ld(32'h60, "R7 load answered under store fence");
      chk("R7 still stalled", {31'b0, core_stall}, 32'd1);
      mem_ready = 1'b1;
      while (core_stall && n < 50) begin @(negedge clk); n++; end
      chk("R7 queue empty at release", 32'(qw - qr), 32'd0);
      #1;
      chk("R7 stores resume", {31'b0, st_ready}, 32'd1);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin
         mem_arr[i] = 32'hA000_0000 + 32'(i);
         ref_arr[i] = 32'hA000_0000 + 32'(i);
      end
      rst_n = 1'b0;
      st_valid = 1'b0; st_addr = '0; st_data = '0;
      ld_valid = 1'b0; ld_addr = '0;
      fence_valid = 1'b0; fence_full = 1'b0;
      mem_ready = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_youngest();
      t_bypass();
      t_drain_race();
      t_full();
      t_same_cycle();
      t_full_fence();
      t_store_fence();
      mem_ready = 1'b1;
      ld(32'h24, "R3 miss on idle queue");
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errs);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errs++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errs);
         $finish;
      end
   end

endmodule